// File: doc/BRIEF.md
# Weighted Priority Command Scheduler

This block decides which command, if any, is handed on at each scheduler tick. Commands enter on a single write port with a class code: low, high or immediate. Low and high commands wait in two separate first-in first-out queues. An immediate command is never queued. It occupies a one-entry holding slot until the next tick claims it, and it beats both queues on that tick.

When no immediate command is waiting, a repeating three-slot pattern (high, high, low) names the preferred queue. If that queue is empty the other one is served, and the pattern still moves on one position. Every command carries a Fletcher-16 checksum over the first `len` payload bytes, and the checksum is verified when the command is selected. A command with a bad checksum is thrown away and uses up its tick. A queued command whose length field is out of range is treated as evidence of storage corruption, and both queues are emptied.

A tick is handled by a small state machine:
- `ST_IDLE` waits for a tick.
- `ST_PICK` selects the source, pops it and latches it as the candidate.
- `ST_VERIFY` checks the length and the checksum.
- `ST_ISSUE` presents the command for one cycle.
- `ST_FLUSH` empties both queues.

The transitions are:
- idle→pick on a tick.
- pick→verify when a source exists.
- pick→idle when nothing is pending.
- verify→issue when both checks pass.
- verify→flush when a queued command has a bad length.
- verify→idle when any other check fails.
- issue→idle and flush→idle unconditionally.

Ticks that arrive while the machine is busy are ignored.

Top module: `cmd_scheduler`

## Requirements
- R1: After reset, `out_valid`, `flushed`, `ovf_high` and `ovf_low` are 0, and both queues are empty, so a tick dispatches nothing.
- R2: An immediate command (class 2'b10) waiting in the holding slot is dispatched on the next tick ahead of any queued command, and it does not move the weighting pattern.
- R3: With both queues non-empty, successive ticks serve the queues in the repeating order high, high, low, starting from high after reset.
- R4: If the queue preferred at a pattern position is empty, the other queue is served and the position still advances. If both queues are empty and no immediate command waits, nothing is dispatched and the position does not move.
- R5: Each tick yields at most one `out_valid` pulse, one cycle long, exactly 3 cycles after the tick cycle. No pulse appears without a tick.
- R6: The checksum is Fletcher-16 over payload bytes 0..len-1, where byte i is `in_payload[8i+7:8i]`. Each sum is reduced modulo 255 to the range 0..254, and `in_sum` = {sum2, sum1}. A command whose checksum does not match is discarded, consumes the tick, and is not dispatched.
- R7: A queued command with length 0 or greater than DATA_BYTES empties both queues when it is selected. `flushed` pulses for one cycle and nothing is dispatched. An immediate command with such a length is only dropped.
- R8: A low (2'b00) or high (2'b01) command written while its queue holds QUEUE_DEPTH entries is rejected, and `ovf_low` or `ovf_high` pulses in the following cycle.
- R9: Within one queue, commands are dispatched in arrival order.
- R10: A dispatched command appears on `out_class`, `out_len` and `out_payload` unchanged. Writes with class 2'b11 are ignored.
- R11: A second immediate command written before a tick replaces the first one, and only the later command is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command write strobe |
| in_class | input | 2 | 00 low, 01 high, 10 immediate, 11 ignored |
| in_len | input | LEN_W | Number of valid payload bytes |
| in_payload | input | 8*DATA_BYTES | Command payload |
| in_sum | input | 16 | Fletcher-16 checksum {sum2,sum1} |
| tick | input | 1 | Scheduler tick |
| out_valid | output | 1 | Dispatch strobe |
| out_class | output | 2 | Class of dispatched command |
| out_len | output | LEN_W | Length of dispatched command |
| out_payload | output | 8*DATA_BYTES | Payload of dispatched command |
| ovf_high | output | 1 | High queue overflow pulse |
| ovf_low | output | 1 | Low queue overflow pulse |
| flushed | output | 1 | Pulse when both queues were cleared |

## Verification
The hardest case to reach is the fallback when one queue is empty. The pattern position is hidden, so the point in the high, high, low cycle where a queue runs dry can only be inferred from the order of earlier dispatches. The stimulus table therefore starts from reset and loads both queues unevenly. It then drains them past the point where the high queue is exhausted, ticks once with both queues empty to show that the position holds, and refills with one command per queue. The classes that come out next pin down where the pattern stands. A flush is triggered only by placing the bad-length entry at the head of the queue that the known pattern position selects.

// File: rtl/cmdsched_pkg.sv
package cmdsched_pkg;

    typedef enum logic [1:0] {
        CLS_LOW  = 2'b00,
        CLS_HIGH = 2'b01,
        CLS_IMM  = 2'b10,
        CLS_RSVD = 2'b11
    } cmd_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_VERIFY,
        ST_ISSUE,
        ST_FLUSH
    } sched_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_IMM,
        SRC_HIGH,
        SRC_LOW
    } sched_src_e;

    localparam int Q_LOW  = 0;
    localparam int Q_HIGH = 1;

endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
    parameter int WIDTH = 51,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic [CW-1:0]    fill;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/cmd_verify.sv
module cmd_verify #(
    parameter int NBYTES = 4,
    parameter int LEN_W  = 3
) (
    input  logic [NBYTES*8-1:0] payload,
    input  logic [LEN_W-1:0]    len,
    input  logic [15:0]         sum,
    output logic                len_ok,
    output logic                sum_ok
);
    logic [8:0] s1;
    logic [8:0] s2;

    always_comb begin
        s1 = '0;
        s2 = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < int'(len)) begin
                s1 = s1 + {1'b0, payload[i*8 +: 8]};
                if (s1 >= 9'd255) begin
                    s1 = s1 - 9'd255;
                end
                s2 = s2 + s1;
                if (s2 >= 9'd255) begin
                    s2 = s2 - 9'd255;
                end
            end
        end
    end

    assign len_ok = (len != '0) && (len <= LEN_W'(NBYTES));
    assign sum_ok = (sum == {s2[7:0], s1[7:0]});

endmodule

// File: rtl/weight_sel.sv
module weight_sel #(
    parameter int HI_SLOTS = 2,
    parameter int LO_SLOTS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic prefer_high
);
    localparam int PERIOD = HI_SLOTS + LO_SLOTS;
    localparam int PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [PW-1:0] pos;

    assign prefer_high = (pos < PW'(HI_SLOTS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (advance) begin
            pos <= (pos == PW'(PERIOD - 1)) ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/cmd_scheduler.sv
module cmd_scheduler
    import cmdsched_pkg::*;
#(
    parameter int DATA_BYTES  = 4,
    parameter int QUEUE_DEPTH = 4,
    parameter int HI_SLOTS    = 2,
    parameter int LO_SLOTS    = 1,
    parameter int LEN_W       = $clog2(DATA_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic [LEN_W-1:0]        in_len,
    input  logic [DATA_BYTES*8-1:0] in_payload,
    input  logic [15:0]             in_sum,
    input  logic                    tick,
    output logic                    out_valid,
    output logic [1:0]              out_class,
    output logic [LEN_W-1:0]        out_len,
    output logic [DATA_BYTES*8-1:0] out_payload,
    output logic                    ovf_high,
    output logic                    ovf_low,
    output logic                    flushed
);
    localparam int DATA_W  = DATA_BYTES * 8;
    localparam int ENTRY_W = LEN_W + 16 + DATA_W;

    sched_state_e state_q;
    sched_state_e state_d;
    sched_src_e   src_sel;

    logic [ENTRY_W-1:0] in_entry;
    logic [ENTRY_W-1:0] imm_entry;
    logic               imm_full;
    logic               imm_wr;
    logic               take_imm;

    logic [ENTRY_W-1:0] q_rdata [2];
    logic [1:0]         q_push;
    logic [1:0]         q_pop;
    logic [1:0]         q_empty;
    logic [1:0]         q_full;
    logic               q_flush;

    logic [ENTRY_W-1:0] cand;
    logic [1:0]         cand_cls;
    logic               cand_queued;
    logic               len_ok;
    logic               sum_ok;
    logic               prefer_high;
    logic               pat_adv;

    assign in_entry = {in_len, in_sum, in_payload};

    // Write decode
    assign imm_wr    = in_valid && (in_class == CLS_IMM);
    assign q_push[Q_LOW]  = in_valid && (in_class == CLS_LOW);
    assign q_push[Q_HIGH] = in_valid && (in_class == CLS_HIGH);

    // Queues
    generate
        for (genvar q = 0; q < 2; q++) begin : g_queue
            cmd_fifo #(
                .WIDTH(ENTRY_W),
                .DEPTH(QUEUE_DEPTH)
            ) u_fifo (
                .clk  (clk),
                .rst_n(rst_n),
                .push (q_push[q]),
                .pop  (q_pop[q]),
                .flush(q_flush),
                .wdata(in_entry),
                .rdata(q_rdata[q]),
                .empty(q_empty[q]),
                .full (q_full[q])
            );
        end
    endgenerate

    weight_sel #(
        .HI_SLOTS(HI_SLOTS),
        .LO_SLOTS(LO_SLOTS)
    ) u_weight (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (pat_adv),
        .prefer_high(prefer_high)
    );

    cmd_verify #(
        .NBYTES(DATA_BYTES),
        .LEN_W (LEN_W)
    ) u_verify (
        .payload(cand[DATA_W-1:0]),
        .len    (cand[ENTRY_W-1 -: LEN_W]),
        .sum    (cand[DATA_W +: 16]),
        .len_ok (len_ok),
        .sum_ok (sum_ok)
    );

    // Source choice, meaningful in ST_PICK
    always_comb begin
        src_sel = SRC_NONE;
        if (imm_full) begin
            src_sel = SRC_IMM;
        end else if (prefer_high) begin
            if (!q_empty[Q_HIGH]) begin
                src_sel = SRC_HIGH;
            end else if (!q_empty[Q_LOW]) begin
                src_sel = SRC_LOW;
            end
        end else begin
            if (!q_empty[Q_LOW]) begin
                src_sel = SRC_LOW;
            end else if (!q_empty[Q_HIGH]) begin
                src_sel = SRC_HIGH;
            end
        end
    end

    assign take_imm     = (state_q == ST_PICK) && (src_sel == SRC_IMM);
    assign q_pop[Q_HIGH] = (state_q == ST_PICK) && (src_sel == SRC_HIGH);
    assign q_pop[Q_LOW]  = (state_q == ST_PICK) && (src_sel == SRC_LOW);
    assign pat_adv      = q_pop[Q_HIGH] || q_pop[Q_LOW];
    assign q_flush      = (state_q == ST_FLUSH);

    // Immediate holding slot: a new write wins over a same-cycle take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_full  <= 1'b0;
            imm_entry <= '0;
        end else begin
            if (take_imm) begin
                imm_full <= 1'b0;
            end
            if (imm_wr) begin
                imm_full  <= 1'b1;
                imm_entry <= in_entry;
            end
        end
    end

    // Candidate register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand        <= '0;
            cand_cls    <= CLS_LOW;
            cand_queued <= 1'b0;
        end else if (state_q == ST_PICK) begin
            unique case (src_sel)
                SRC_IMM: begin
                    cand        <= imm_entry;
                    cand_cls    <= CLS_IMM;
                    cand_queued <= 1'b0;
                end
                SRC_HIGH: begin
                    cand        <= q_rdata[Q_HIGH];
                    cand_cls    <= CLS_HIGH;
                    cand_queued <= 1'b1;
                end
                SRC_LOW: begin
                    cand        <= q_rdata[Q_LOW];
                    cand_cls    <= CLS_LOW;
                    cand_queued <= 1'b1;
                end
                default: begin
                    cand        <= cand;
                    cand_cls    <= cand_cls;
                    cand_queued <= cand_queued;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick) begin
                    state_d = ST_PICK;
                end
            end
            ST_PICK: begin
                state_d = (src_sel == SRC_NONE) ? ST_IDLE : ST_VERIFY;
            end
            ST_VERIFY: begin
                if (!len_ok && cand_queued) begin
                    state_d = ST_FLUSH;
                end else if (!len_ok || !sum_ok) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: state_d = ST_IDLE;
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid   = (state_q == ST_ISSUE);
        flushed     = (state_q == ST_FLUSH);
        out_class   = cand_cls;
        out_len     = cand[ENTRY_W-1 -: LEN_W];
        out_payload = cand[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_high <= 1'b0;
            ovf_low  <= 1'b0;
        end else begin
            ovf_high <= q_push[Q_HIGH] && q_full[Q_HIGH];
            ovf_low  <= q_push[Q_LOW] && q_full[Q_LOW];
        end
    end

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int DATA_BYTES = 4,
    parameter int LEN_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             in_valid,
    input logic [1:0]       in_class,
    input logic             out_valid,
    input logic [1:0]       out_class,
    input logic [LEN_W-1:0] out_len,
    input logic             ovf_high,
    input logic             ovf_low,
    input logic             flushed,
    input logic [1:0]       q_full,
    input logic [1:0]       q_empty
);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_tick_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tick, 3));

    assert_clean_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_class != 2'b11) && (out_len != '0)
                      && (out_len <= LEN_W'(DATA_BYTES)));

    assert_no_overflow_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_high |-> $past(in_valid && (in_class == 2'b01) && q_full[1]));

    assert_no_overflow_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_low |-> $past(in_valid && (in_class == 2'b00) && q_full[0]));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flushed |=> (q_empty == 2'b11));

    assert_flush_no_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flushed |-> !out_valid);

endmodule

bind cmd_scheduler sched_checker #(
    .DATA_BYTES(DATA_BYTES),
    .LEN_W     (LEN_W)
) u_sched_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .in_valid (in_valid),
    .in_class (in_class),
    .out_valid(out_valid),
    .out_class(out_class),
    .out_len  (out_len),
    .ovf_high (ovf_high),
    .ovf_low  (ovf_low),
    .flushed  (flushed),
    .q_full   (q_full),
    .q_empty  (q_empty)
);

// File: tb/tb_cmd_scheduler.sv
module tb_cmd_scheduler;
    localparam int DATA_BYTES = 4;
    localparam int DEPTH      = 4;
    localparam int LEN_W      = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [1:0]              in_class = 2'b00;
    logic [LEN_W-1:0]        in_len = '0;
    logic [DATA_BYTES*8-1:0] in_payload = '0;
    logic [15:0]             in_sum = '0;
    logic                    tick = 1'b0;
    logic                    out_valid;
    logic [1:0]              out_class;
    logic [LEN_W-1:0]        out_len;
    logic [DATA_BYTES*8-1:0] out_payload;
    logic                    ovf_high;
    logic                    ovf_low;
    logic                    flushed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmd_scheduler #(
        .DATA_BYTES (DATA_BYTES),
        .QUEUE_DEPTH(DEPTH)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_class   (in_class),
        .in_len     (in_len),
        .in_payload (in_payload),
        .in_sum     (in_sum),
        .tick       (tick),
        .out_valid  (out_valid),
        .out_class  (out_class),
        .out_len    (out_len),
        .out_payload(out_payload),
        .ovf_high   (ovf_high),
        .ovf_low    (ovf_low),
        .flushed    (flushed)
    );

    // kind: 0 write, 1 tick expecting a dispatch, 2 tick expecting none
    localparam int NV = 24;
    localparam logic [35:0] VEC [NV] = '{
        {2'd0, 2'b01, 32'h1111_0001},
        {2'd0, 2'b01, 32'h1111_0002},
        {2'd0, 2'b01, 32'h1111_0003},
        {2'd0, 2'b00, 32'h2222_0001},
        {2'd0, 2'b00, 32'h2222_0002},
        {2'd0, 2'b00, 32'h2222_0003},
        {2'd1, 2'b01, 32'h1111_0001},
        {2'd1, 2'b01, 32'h1111_0002},
        {2'd1, 2'b00, 32'h2222_0001},
        {2'd1, 2'b01, 32'h1111_0003},
        {2'd1, 2'b00, 32'h2222_0002},
        {2'd1, 2'b00, 32'h2222_0003},
        {2'd2, 2'b00, 32'h0000_0000},
        {2'd0, 2'b00, 32'h2222_0004},
        {2'd0, 2'b01, 32'h1111_0004},
        {2'd1, 2'b01, 32'h1111_0004},
        {2'd0, 2'b10, 32'h3333_0001},
        {2'd1, 2'b10, 32'h3333_0001},
        {2'd1, 2'b00, 32'h2222_0004},
        {2'd0, 2'b01, 32'h1111_0005},
        {2'd0, 2'b00, 32'h2222_0005},
        {2'd1, 2'b00, 32'h2222_0005},
        {2'd1, 2'b01, 32'h1111_0005},
        {2'd2, 2'b00, 32'h0000_0000}
    };

    function automatic logic [15:0] fl16(input logic [31:0] d, input int n);
        int a = 0;
        int b = 0;
        for (int i = 0; i < n && i < 4; i++) begin
            a = (a + int'(d[i*8 +: 8])) % 255;
            b = (b + a) % 255;
        end
        return {b[7:0], a[7:0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input logic [1:0] cls, input int len, input logic [31:0] d,
                       input bit bad_sum, output bit ovh, output bit ovl);
        @(negedge clk);
        in_valid   = 1'b1;
        in_class   = cls;
        in_len     = LEN_W'(len);
        in_payload = d;
        in_sum     = fl16(d, len) ^ (bad_sum ? 16'h0001 : 16'h0000);
        @(negedge clk);
        in_valid = 1'b0;
        ovh = ovf_high;
        ovl = ovf_low;
    endtask

    task automatic do_tick(output int n, output logic [1:0] cls, output logic [31:0] d,
                           output logic [LEN_W-1:0] l, output bit fl);
        n = 0; cls = 2'b00; d = '0; l = '0; fl = 1'b0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int c = 0; c < 6; c++) begin
            if (out_valid) begin
                n++;
                cls = out_class;
                d   = out_payload;
                l   = out_len;
            end
            if (flushed) fl = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [1:0] cls;
        logic [31:0] d;
        logic [LEN_W-1:0] l;
        bit fl, ovh, ovl;

        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 flushed", flushed, 0);
        check("R1 ovf", {ovf_high, ovf_low}, 0);
        do_tick(n, cls, d, l, fl);
        check("R1 tick after reset", n, 0);

        do_reset();
        // R3 R4 R9 R2: vector table from a fresh pattern position
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][35:34] == 2'd0) begin
                put(VEC[k][33:32], 4, VEC[k][31:0], 1'b0, ovh, ovl);
            end else begin
                do_tick(n, cls, d, l, fl);
                if (VEC[k][35:34] == 2'd1) begin
                    check("R3/R4/R9/R2 count", n, 1);
                    check("R3/R4/R9/R2 class", cls, VEC[k][33:32]);
                    check("R9/R10 payload", d, VEC[k][31:0]);
                end else begin
                    check("R4 empty tick", n, 0);
                end
            end
        end

        // R5: no dispatch without a tick
        put(2'b01, 4, 32'hAAAA_0001, 1'b0, ovh, ovl);
        n = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (out_valid) n++;
        end
        check("R5 no tick no dispatch", n, 0);
        do_tick(n, cls, d, l, fl);
        check("R5 one per tick", n, 1);

        // R11: later immediate replaces earlier one
        put(2'b10, 4, 32'hBEEF_0001, 1'b0, ovh, ovl);
        put(2'b10, 4, 32'hBEEF_0002, 1'b0, ovh, ovl);
        do_tick(n, cls, d, l, fl);
        check("R11 replaced payload", d, 32'hBEEF_0002);
        check("R2 immediate class", cls, 2'b10);
        do_tick(n, cls, d, l, fl);
        check("R11 first immediate gone", n, 0);

        // R6: bad checksum discarded, partial-length sum honoured
        put(2'b01, 4, 32'hC0DE_0001, 1'b1, ovh, ovl);
        put(2'b01, 2, 32'hFFFF_9A7B, 1'b0, ovh, ovl);
        do_tick(n, cls, d, l, fl);
        check("R6 bad sum not dispatched", n, 0);
        do_tick(n, cls, d, l, fl);
        check("R6 next good dispatched", n, 1);
        check("R6 partial length payload", d, 32'hFFFF_9A7B);
        check("R10 length kept", l, 2);

        // R10: reserved class ignored
        put(2'b11, 4, 32'h0BAD_0BAD, 1'b0, ovh, ovl);
        do_tick(n, cls, d, l, fl);
        check("R10 reserved ignored", n, 0);

        // R7: bad length at head flushes both queues
        do_reset();
        put(2'b01, 0, 32'h1234_5678, 1'b0, ovh, ovl);
        put(2'b01, 4, 32'h1234_0002, 1'b0, ovh, ovl);
        put(2'b00, 4, 32'h5678_0003, 1'b0, ovh, ovl);
        do_tick(n, cls, d, l, fl);
        check("R7 no dispatch on flush", n, 0);
        check("R7 flushed pulse", fl, 1);
        do_tick(n, cls, d, l, fl);
        check("R7 queues cleared", n, 0);
        put(2'b10, 6, 32'h1357_2468, 1'b0, ovh, ovl);
        put(2'b00, 4, 32'h5678_0004, 1'b0, ovh, ovl);
        do_tick(n, cls, d, l, fl);
        check("R7 bad immediate no flush", fl, 0);
        check("R7 bad immediate dropped", n, 0);
        do_tick(n, cls, d, l, fl);
        check("R7 queue kept after immediate drop", d, 32'h5678_0004);

        // R8: overflow of low queue
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            put(2'b00, 4, 32'h7700_0000 + k, 1'b0, ovh, ovl);
            check("R8 no overflow below depth", ovl, 0);
        end
        put(2'b00, 4, 32'h7700_00FF, 1'b0, ovh, ovl);
        check("R8 overflow low", ovl, 1);
        check("R8 no overflow high", ovh, 0);
        for (int k = 0; k < DEPTH; k++) begin
            do_tick(n, cls, d, l, fl);
            check("R8/R9 drained order", d, 32'h7700_0000 + k);
        end
        do_tick(n, cls, d, l, fl);
        check("R8 rejected entry absent", n, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule